// File: doc/BRIEF.md
# Data Cache Store Merge Path

This block takes one processor store at a time after its permission check has passed and completes it along one of two paths. When the store hits the data cache, the block merges the store data into the addressed 32-bit word of the cached line. It picks the byte lane from the low address bits and the endian mode. It returns the merged word for write-back into the line, together with a one-hot mark saying which half of the line is now dirty.

When the store misses, the block routes it by the page's bufferable attribute. A bufferable store goes to the write buffer if that buffer is enabled, and directly to memory if it is not. A non-bufferable store first asks the write buffer to drain and waits until the buffer reports empty, then writes memory. Both downstream ports use a valid/ready handshake. While a miss is in progress the block stalls new stores by dropping `st_ready`.

Top module: `dstore_merge`

## Requirements
- R1: A hit store with size code 2 (word; size codes are byte=0, halfword=1, word=2) writes the store data unchanged as the new line word, at word index `st_addr[4:2]`, one cycle after acceptance.
- R2: A hit halfword store changes only the 16 bits starting at bit offset 8 × ((big_endian ? 2 : 0) XOR `st_addr[1:0]` & 2). Those bits take `st_data[15:0]`, and the other bits keep `line_rd_word`.
- R3: A hit byte store changes only the 8 bits starting at bit offset 8 × ((big_endian ? 3 : 0) XOR `st_addr[1:0]`). Those bits take `st_data[7:0]`, and all other bits are kept.
- R4: With every hit write, `line_dirty_set` is 2'b01 when the word index is below half the words per line, and 2'b10 otherwise. It is 0 when no line write is issued.
- R5: A miss with bufferable set and the write buffer enabled raises a write-buffer request with byte count 4, 2 or 1 for word, halfword or byte. Its data is `st_data` zero-extended from the lowest 32, 16 or 8 bits. No memory request is raised.
- R6: The downstream address is `st_pa` with bits 1:0 cleared. For a halfword it is then ORed with `st_addr & 2`, and for a byte it is ORed with `st_addr & 3`.
- R7: A miss with bufferable clear holds `wb_drain` high for at least one cycle. It raises no memory request until the cycle after `wb_empty` is seen high in the drain state.
- R8: A miss that is bufferable, with the write buffer disabled, raises a memory request one cycle after acceptance and never raises `wb_drain` or a write-buffer request.
- R9: After reset, and after each miss completes, `busy` is 0 and `st_ready` is 1. From acceptance of a miss until its downstream handshake, `busy` is 1, `st_ready` is 0, and stores offered meanwhile are not taken.
- R10: A downstream request stays valid, with stable address, data and byte count, until its ready is seen. It drops in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 32 | Virtual store address |
| st_size | input | 2 | 0 byte, 1 halfword, 2 word |
| st_data | input | 32 | Store data, right-aligned |
| st_hit | input | 1 | Store hits a cached line |
| st_bufferable | input | 1 | Page bufferable attribute |
| st_pa | input | 32 | Translated physical address |
| wb_enable | input | 1 | Write buffer enabled |
| big_endian | input | 1 | Big-endian lane mode |
| line_rd_word | input | 32 | Current content of the addressed line word |
| line_wr_en | output | 1 | Write merged word into the line |
| line_wr_idx | output | 3 | Word index within the line |
| line_wr_data | output | 32 | Merged word |
| line_dirty_set | output | 2 | Dirty mark, bit0 first half, bit1 last half |
| wb_req_valid | output | 1 | Write-buffer request valid |
| wb_req_ready | input | 1 | Write buffer accepts |
| wb_req_addr | output | 32 | Write-buffer byte address |
| wb_req_data | output | 32 | Write-buffer data |
| wb_req_bytes | output | 3 | Byte count 4, 2 or 1 |
| wb_drain | output | 1 | Request to empty the write buffer |
| wb_empty | input | 1 | Write buffer holds nothing |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_data | output | 32 | Memory data |
| mem_req_bytes | output | 3 | Byte count 4, 2 or 1 |
| busy | output | 1 | Miss in progress |

## Verification
The hardest case to reach is a non-bufferable miss while the write buffer stays non-empty for several cycles, with stores still offered during the stall. Only then does a premature memory write or an extra acceptance show up. The stimulus holds `wb_empty` low for a random 0 to 3 cycles and `mem_req_ready` low for a random 0 to 3 cycles. It keeps `st_valid` high with a hit store throughout, then checks that no line write or memory request appears early. Directed hit stores cover every lane offset in both endian modes and the word indices on both sides of the half-line boundary.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } st_size_e;

    typedef enum logic [1:0] {
        RT_IDLE  = 2'd0,
        RT_PUSH  = 2'd1,
        RT_DRAIN = 2'd2,
        RT_MEMWR = 2'd3
    } route_st_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic [2:0]  bytes;
    } wr_req_t;

    function automatic logic [4:0] lane_shift(input st_size_e sz, input logic be,
                                              input logic [1:0] lo);
        logic [1:0] lane;
        case (sz)
            SZ_HALF: lane = {be, 1'b0} ^ {lo[1], 1'b0};
            SZ_BYTE: lane = {be, be} ^ lo;
            default: lane = 2'd0;
        endcase
        return {lane, 3'b000};
    endfunction

    function automatic logic [2:0] byte_count(input st_size_e sz);
        case (sz)
            SZ_HALF: return 3'd2;
            SZ_BYTE: return 3'd1;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] size_data(input st_size_e sz, input logic [31:0] d);
        case (sz)
            SZ_HALF: return {16'h0, d[15:0]};
            SZ_BYTE: return {24'h0, d[7:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input st_size_e sz);
        case (sz)
            SZ_HALF: return 32'h0000_FFFF;
            SZ_BYTE: return 32'h0000_00FF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dsm_lane_merge.sv
module dsm_lane_merge
    import dsm_pkg::*;
(
    input  logic [31:0] old_word,
    input  logic [31:0] new_data,
    input  st_size_e    size,
    input  logic        big_endian,
    input  logic [1:0]  addr_lo,
    output logic [31:0] merged
);
    logic [4:0]  shift;
    logic [31:0] mask_sh;
    logic [31:0] data_sh;

    always_comb begin
        shift   = lane_shift(size, big_endian, addr_lo);
        mask_sh = lane_mask(size) << shift;
        data_sh = (new_data & lane_mask(size)) << shift;
        merged  = (old_word & ~mask_sh) | data_sh;
    end

    always_comb begin
        if (size == SZ_WORD)
            assert (merged == new_data) else $error("AST_WORD_REPLACE"); // R1
    end
endmodule

// File: rtl/dsm_hit_stage.sv
module dsm_hit_stage
    import dsm_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int HALF_IDX  = LINE_WORDS / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      old_word,
    input  logic [31:0]      merged,
    input  st_size_e         size,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [31:0]      wr_data,
    output logic [1:0]       dirty_set
);
    logic [31:0] old_q;
    st_size_e    size_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            dirty_set <= 2'b00;
            old_q     <= '0;
            size_q    <= SZ_WORD;
        end else begin
            wr_en <= take;
            if (take) begin
                wr_idx    <= idx;
                wr_data   <= merged;
                old_q     <= old_word;
                size_q    <= size;
                dirty_set <= (int'(idx) < HALF_IDX) ? 2'b01 : 2'b10;
            end else begin
                dirty_set <= 2'b00;
            end
        end
    end

    AST_DIRTY_ONE_HALF: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $onehot(dirty_set)); // R4
    AST_DIRTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> dirty_set == 2'b00); // R4
    AST_HALF_LANE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && size_q == SZ_HALF) |-> $countones(wr_data ^ old_q) <= 16); // R2
    AST_BYTE_LANE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && size_q == SZ_BYTE) |-> $countones(wr_data ^ old_q) <= 8); // R3
endmodule

// File: rtl/dsm_route_ctrl.sv
module dsm_route_ctrl
    import dsm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take_miss,
    input  logic    miss_buf,
    input  logic    wb_enable,
    input  wr_req_t req_in,
    input  logic    wb_req_ready,
    input  logic    wb_empty,
    input  logic    mem_req_ready,
    output logic    busy,
    output logic    wb_req_valid,
    output logic    wb_drain,
    output logic    mem_req_valid,
    output wr_req_t req_q
);
    route_st_e state, state_nx;
    logic      nonbuf_q;

    always_comb begin
        state_nx = state;
        case (state)
            RT_IDLE: begin
                if (take_miss) begin
                    if (miss_buf && wb_enable) state_nx = RT_PUSH;
                    else if (miss_buf)         state_nx = RT_MEMWR;
                    else                       state_nx = RT_DRAIN;
                end
            end
            RT_PUSH:  if (wb_req_ready)  state_nx = RT_IDLE;
            RT_DRAIN: if (wb_empty)      state_nx = RT_MEMWR;
            RT_MEMWR: if (mem_req_ready) state_nx = RT_IDLE;
            default:  state_nx = RT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RT_IDLE;
            req_q    <= '0;
            nonbuf_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == RT_IDLE && take_miss) begin
                req_q    <= req_in;
                nonbuf_q <= !miss_buf;
            end
        end
    end

    always_comb begin
        busy          = (state != RT_IDLE);
        wb_req_valid  = (state == RT_PUSH);
        wb_drain      = (state == RT_DRAIN);
        mem_req_valid = (state == RT_MEMWR);
    end

    AST_DRAIN_BEFORE_MEM: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req_valid) && nonbuf_q) |-> $past(wb_empty)); // R7
    AST_NO_DRAIN_BUFFERED: assert property (@(posedge clk) disable iff (rst)
        (busy && !nonbuf_q) |-> !wb_drain); // R8
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
        !(wb_req_valid && mem_req_valid)); // R5
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wb_req_valid && !wb_req_ready) |=> (wb_req_valid && $stable(req_q))); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(req_q))); // R10
    AST_MEM_DROP: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R10
endmodule

// File: rtl/dstore_merge.sv
module dstore_merge
    import dsm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [31:0]       st_data,
    input  logic              st_hit,
    input  logic              st_bufferable,
    input  logic [ADDR_W-1:0] st_pa,
    input  logic              wb_enable,
    input  logic              big_endian,
    input  logic [31:0]       line_rd_word,
    output logic              line_wr_en,
    output logic [IDX_W-1:0]  line_wr_idx,
    output logic [31:0]       line_wr_data,
    output logic [1:0]        line_dirty_set,
    output logic              wb_req_valid,
    input  logic              wb_req_ready,
    output logic [ADDR_W-1:0] wb_req_addr,
    output logic [31:0]       wb_req_data,
    output logic [2:0]        wb_req_bytes,
    output logic              wb_drain,
    input  logic              wb_empty,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [31:0]       mem_req_data,
    output logic [2:0]        mem_req_bytes,
    output logic              busy
);
    st_size_e    size_e;
    logic        take, take_hit, take_miss;
    logic [31:0] merged;
    logic [31:0] pa_full;
    logic [1:0]  lo_keep;
    wr_req_t     req_in, req_q;

    always_comb begin
        size_e    = st_size_e'(st_size);
        st_ready  = !busy;
        take      = st_valid && st_ready;
        take_hit  = take && st_hit;
        take_miss = take && !st_hit;
        case (size_e)
            SZ_HALF: lo_keep = {st_addr[1], 1'b0};
            SZ_BYTE: lo_keep = st_addr[1:0];
            default: lo_keep = 2'b00;
        endcase
        pa_full        = 32'(st_pa);
        req_in.addr    = {pa_full[31:2], lo_keep};
        req_in.data    = size_data(size_e, st_data);
        req_in.bytes   = byte_count(size_e);
    end

    dsm_lane_merge u_merge (
        .old_word   (line_rd_word),
        .new_data   (st_data),
        .size       (size_e),
        .big_endian (big_endian),
        .addr_lo    (st_addr[1:0]),
        .merged     (merged)
    );

    dsm_hit_stage #(.LINE_WORDS(LINE_WORDS)) u_hit (
        .clk       (clk),
        .rst       (rst),
        .take      (take_hit),
        .idx       (st_addr[IDX_W+1:2]),
        .old_word  (line_rd_word),
        .merged    (merged),
        .size      (size_e),
        .wr_en     (line_wr_en),
        .wr_idx    (line_wr_idx),
        .wr_data   (line_wr_data),
        .dirty_set (line_dirty_set)
    );

    dsm_route_ctrl u_route (
        .clk           (clk),
        .rst           (rst),
        .take_miss     (take_miss),
        .miss_buf      (st_bufferable),
        .wb_enable     (wb_enable),
        .req_in        (req_in),
        .wb_req_ready  (wb_req_ready),
        .wb_empty      (wb_empty),
        .mem_req_ready (mem_req_ready),
        .busy          (busy),
        .wb_req_valid  (wb_req_valid),
        .wb_drain      (wb_drain),
        .mem_req_valid (mem_req_valid),
        .req_q         (req_q)
    );

    always_comb begin
        wb_req_addr   = ADDR_W'(req_q.addr);
        wb_req_data   = req_q.data;
        wb_req_bytes  = req_q.bytes;
        mem_req_addr  = ADDR_W'(req_q.addr);
        mem_req_data  = req_q.data;
        mem_req_bytes = req_q.bytes;
    end

    AST_STALL_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        busy |=> !line_wr_en); // R9
endmodule

// File: tb/dstore_merge_bench.sv
`timescale 1ns/1ps
module dstore_merge_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, st_ready, st_hit, st_bufferable, wb_enable, big_endian;
    logic [31:0] st_addr, st_data, st_pa, line_rd_word;
    logic [1:0]  st_size;
    logic        line_wr_en;
    logic [2:0]  line_wr_idx;
    logic [31:0] line_wr_data;
    logic [1:0]  line_dirty_set;
    logic        wb_req_valid, wb_req_ready, wb_drain, wb_empty;
    logic [31:0] wb_req_addr, wb_req_data, mem_req_addr, mem_req_data;
    logic [2:0]  wb_req_bytes, mem_req_bytes;
    logic        mem_req_valid, mem_req_ready, busy;

    int vectors = 0;
    int fails   = 0;
    int seed_dummy;

    always #2.5 clk = ~clk;

    dstore_merge u_dstore_merge (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [31:0] d,
                                              input logic [1:0] sz, input logic be,
                                              input logic [1:0] lo);
        int off;
        logic [31:0] r;
        r = old;
        if (sz == 2) r = d;
        else if (sz == 1) begin
            off = 8 * (int'(be ? 2 : 0) ^ int'(lo & 2'd2));
            for (int b = 0; b < 16; b++) r[off + b] = d[b];
        end else begin
            off = 8 * (int'(be ? 3 : 0) ^ int'(lo));
            for (int b = 0; b < 8; b++) r[off + b] = d[b];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] pa, input logic [31:0] va,
                                             input logic [1:0] sz);
        logic [31:0] base;
        base = pa & 32'hFFFF_FFFC;
        if (sz == 1) return base | (va & 32'd2);
        if (sz == 0) return base | (va & 32'd3);
        return base;
    endfunction

    function automatic logic [2:0] exp_bytes(input logic [1:0] sz);
        return (sz == 2) ? 3'd4 : (sz == 1) ? 3'd2 : 3'd1;
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] d, input logic [1:0] sz);
        return (sz == 2) ? d : (sz == 1) ? {16'h0, d[15:0]} : {24'h0, d[7:0]};
    endfunction

    task automatic check_req(input logic [31:0] a, input logic [31:0] d, input logic [2:0] n,
                             input logic [31:0] ea, input logic [31:0] ed, input logic [1:0] sz,
                             input string tag);
        chk(a == ea, {"R6 addr ", tag}, a, ea);
        chk(d == ed, {"R5 data ", tag}, d, ed);
        chk(n == exp_bytes(sz), {"R5 bytes ", tag}, 32'(n), 32'(exp_bytes(sz)));
    endtask

    task automatic do_store(input logic hit, input logic buf_a, input logic wben,
                            input logic be, input logic [31:0] va, input logic [1:0] sz,
                            input logic [31:0] d, input logic [31:0] pa,
                            input logic [31:0] old, input int d1, input int d2);
        logic [31:0] ea, ed;
        ea = exp_addr(pa, va, sz);
        ed = exp_data(d, sz);
        @(negedge clk);
        st_valid = 1; st_hit = hit; st_bufferable = buf_a; wb_enable = wben;
        big_endian = be; st_addr = va; st_size = sz; st_data = d; st_pa = pa;
        line_rd_word = old; wb_req_ready = 0; mem_req_ready = 0; wb_empty = 0;
        chk(st_ready == 1'b1, "R9 ready before store", 32'(st_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        if (hit) begin
            st_valid = 0;
            chk(line_wr_en == 1'b1, "R1 line write", 32'(line_wr_en), 32'd1);
            chk(line_wr_idx == va[4:2], "R1 index", 32'(line_wr_idx), 32'(va[4:2]));
            chk(line_wr_data == exp_merge(old, d, sz, be, va[1:0]),
                (sz == 2) ? "R1 word" : (sz == 1) ? "R2 half" : "R3 byte",
                line_wr_data, exp_merge(old, d, sz, be, va[1:0]));
            chk(line_dirty_set == ((va[4:2] < 3'd4) ? 2'b01 : 2'b10), "R4 dirty",
                32'(line_dirty_set), (va[4:2] < 3'd4) ? 32'd1 : 32'd2);
            chk(!wb_req_valid && !mem_req_valid && !busy, "R9 hit no miss", 32'(busy), 32'd0);
            return;
        end
        // stall: offer a hit store meanwhile; it must not be taken
        st_hit = 1;
        if (!buf_a) begin
            for (int c = 0; c <= d1; c++) begin
                chk(wb_drain == 1'b1, "R7 drain", 32'(wb_drain), 32'd1);
                chk(mem_req_valid == 1'b0, "R7 no early mem", 32'(mem_req_valid), 32'd0);
                chk(busy && !st_ready, "R9 busy in drain", 32'(st_ready), 32'd0);
                chk(line_wr_en == 1'b0, "R9 stalled store", 32'(line_wr_en), 32'd0);
                if (c == d1) wb_empty = 1;
                @(posedge clk);
                @(negedge clk);
            end
        end
        for (int c = 0; c <= d2; c++) begin
            chk(busy && !st_ready, "R9 busy", 32'(st_ready), 32'd0);
            chk(line_wr_en == 1'b0, "R9 stalled store", 32'(line_wr_en), 32'd0);
            if (buf_a && wben) begin
                chk(wb_req_valid && !mem_req_valid, "R5 wb route", 32'(mem_req_valid), 32'd0);
                check_req(wb_req_addr, wb_req_data, wb_req_bytes, ea, ed, sz, "wb R10");
            end else begin
                chk(mem_req_valid && !wb_req_valid, "R8 mem route", 32'(wb_req_valid), 32'd0);
                if (buf_a)
                    chk(wb_drain == 1'b0, "R8 no drain", 32'(wb_drain), 32'd0);
                check_req(mem_req_addr, mem_req_data, mem_req_bytes, ea, ed, sz, "mem R10");
            end
            if (c == d2) begin
                wb_req_ready = 1; mem_req_ready = 1; st_valid = 0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        wb_req_ready = 0; mem_req_ready = 0;
        chk(!busy && st_ready, "R9 idle after miss", 32'(busy), 32'd0);
        chk(!wb_req_valid && !mem_req_valid, "R10 drop after handshake",
            32'(wb_req_valid | mem_req_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5EED_1234);
        rst = 1; st_valid = 0; st_hit = 0; st_bufferable = 0; wb_enable = 0;
        big_endian = 0; st_addr = 0; st_size = 0; st_data = 0; st_pa = 0;
        line_rd_word = 0; wb_req_ready = 0; mem_req_ready = 0; wb_empty = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && st_ready && !line_wr_en && line_dirty_set == 0, "R9 reset state",
            32'(busy), 32'd0);
        chk(!wb_req_valid && !mem_req_valid && !wb_drain, "R9 reset quiet",
            32'(wb_req_valid), 32'd0);

        // directed: every lane, both endian modes, both halves of the line
        for (int e = 0; e < 2; e++)
            for (int lo = 0; lo < 4; lo++) begin
                do_store(1, 0, 0, e[0], {27'h0, 3'd3, lo[1:0]}, 2'd1, 32'hABCD_1234,
                         32'h0, 32'h1111_2222, 0, 0);
                do_store(1, 0, 0, e[0], {27'h0, 3'd4, lo[1:0]}, 2'd0, 32'h0000_00C5,
                         32'h0, 32'h8765_4321, 0, 0);
            end
        do_store(1, 1, 1, 0, 32'h0000_001C, 2'd2, 32'hDEAD_BEEF, 0, 32'h0, 0, 0);
        // directed miss corners
        do_store(0, 0, 1, 0, 32'h0000_0003, 2'd0, 32'hFFFF_FF5A, 32'h1234_5677, 0, 3, 2);
        do_store(0, 0, 0, 1, 32'h0000_0002, 2'd1, 32'h9999_8888, 32'h0000_1003, 0, 0, 0);
        do_store(0, 1, 1, 0, 32'h0000_0006, 2'd1, 32'h0102_0304, 32'hFFFF_FFFF, 0, 0, 3);
        do_store(0, 1, 0, 0, 32'h0000_0001, 2'd0, 32'h0000_00A1, 32'h4000_0000, 0, 0, 1);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] sz;
            sz = 2'($urandom % 3);
            do_store(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     $urandom, sz, $urandom, $urandom, $urandom,
                     int'($urandom % 4), int'($urandom % 4));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule